// File: doc/BRIEF.md
# Virtual Interrupt Take Arbiter

This block sits beside a processor core's exception logic and decides, once per cycle, whether an interrupt exception should be taken and which one. For each of three interrupt kinds (IRQ, FIQ, SError) it combines the following inputs:

- the core's current privilege level and security state;
- a per-kind redirect bit that sends physical interrupts to the hypervisor level and turns on virtual delivery of that kind;
- software-set virtual pending bits and virtual request lines from an external interrupt controller;
- the physical request lines;
- the three processor-state mask bits.

The mask bits change meaning with the redirect bits. A kind whose redirect bit is set at levels 0/1 has its mask applied to the virtual request, and its physical request then goes to level 2 whatever the mask says. Virtual requests can only be taken at levels 0 and 1. At levels 2 and 3 they wait and are taken once the core drops back, if they are still present and unmasked.

The winner is chosen by a fixed priority. The block reports it through a registered one-cycle take pulse together with its kind, a virtual flag and the target level. After a take, the block offers no new take until the core acknowledges the previous one. Vector fetch, context save and the interrupt controller itself belong to other blocks.

Top module: `virq_take_unit`

## Requirements
- R1: A virtual request is taken only when `cur_el` is 0 or 1. At level 2 or 3 it produces no take. It is taken in the cycle after the core returns to level 0/1, provided it is still requested and unmasked.
- R2: A physical request whose kind has its `route_to_hyp` bit set targets level 2. From level 0/1 it is taken whatever its mask bit is. From level 2 it is taken only when its mask bit is 0. From level 3 it is never taken.
- R3: A physical request whose redirect bit is 0 is taken to level 1 from level 0/1 when its mask bit is 0, and is not taken from level 2 or 3. A virtual request of a kind whose redirect bit is 0 is never taken.
- R4: The virtual request of a kind is the OR of its `soft_vpend` bit and, for IRQ (bit 0) and FIQ (bit 1), the matching `ctl_vreq` line. SError (bit 2) has only the software bit.
- R5: With the redirect bit set at level 0/1, the kind's `pstate_mask` bit (bit 0 I, bit 1 F, bit 2 A) blocks the virtual request. A taken virtual interrupt always targets level 1.
- R6: Each kind follows its own redirect and mask bits. For example, a non-redirected physical FIQ and a redirected IRQ are handled independently in the same configuration.
- R7: When `secure` is 1, virtual requests are taken only if `sec_hyp_en` is 1.
- R8: Among takeable requests the order is: physical SError, virtual SError, physical FIQ, virtual FIQ, physical IRQ, virtual IRQ.
- R9: `take_kind` encodes 2'b00 IRQ, 2'b01 FIQ, 2'b10 SError. `take_level` holds the target level as a number. `take_virtual` is 1 for a virtual interrupt. The three fields are valid with the pulse and held until the next take.
- R10: `take_pulse` rises on the clock edge after the inputs that make a request takeable, and lasts exactly one cycle. No further pulse occurs until `take_ack` has been sampled high. A request still present then produces a pulse on the edge after the acknowledge edge.
- R11: While `rst` is high, all outputs are 0 and any wait for an acknowledge is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| secure | input | 1 | Core is in secure state |
| sec_hyp_en | input | 1 | Secure hypervisor level implemented and enabled |
| route_to_hyp | input | 3 | Per-kind redirect bits (0 IRQ, 1 FIQ, 2 SError) |
| soft_vpend | input | 3 | Software virtual pending bits, per kind |
| ctl_vreq | input | 2 | Controller virtual IRQ (0) and FIQ (1) lines |
| phys_req | input | 3 | Physical request lines, per kind |
| pstate_mask | input | 3 | Processor-state masks: 0 I, 1 F, 2 A |
| take_ack | input | 1 | Core has accepted the last take |
| take_pulse | output | 1 | One-cycle take strobe |
| take_kind | output | 2 | Kind of the taken exception |
| take_virtual | output | 1 | Taken exception is virtual |
| take_level | output | 2 | Target privilege level |

## Verification
The assertions assume that every input is a level that holds steady between edges. They also assume that `take_ack` is raised only after a take has been reported. Otherwise an acknowledge could clear a wait that has not begun, which the acknowledge tracker does not model. The bench drives all inputs on falling edges, and it raises the acknowledge only after each observed pulse or as the cleanup step of a vector. Every `cur_el` value, secure setting and redirect combination it uses is a legal core state.

// File: rtl/vint_pkg.sv
package vint_pkg;

    localparam int EL_W       = 2;
    localparam int NUM_KINDS  = 3;
    localparam int NUM_CTL    = 2;
    localparam int KIND_W     = 2;

    localparam logic [EL_W-1:0] LVL_USER   = 2'd0;
    localparam logic [EL_W-1:0] LVL_KERNEL = 2'd1;
    localparam logic [EL_W-1:0] LVL_HYP    = 2'd2;
    localparam logic [EL_W-1:0] LVL_MON    = 2'd3;

    typedef enum logic [KIND_W-1:0] {
        KIND_IRQ  = 2'b00,
        KIND_FIQ  = 2'b01,
        KIND_SERR = 2'b10
    } kind_e;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic              virt;
        logic [EL_W-1:0]   level;
    } take_info_t;

    localparam take_info_t TAKE_NONE = '{valid: 1'b0, kind: KIND_IRQ, virt: 1'b0, level: '0};

    function automatic logic is_guest_level(input logic [EL_W-1:0] el);
        return (el == LVL_USER) || (el == LVL_KERNEL);
    endfunction

    function automatic kind_e kind_of(input int idx);
        kind_e k;
        case (idx)
            1:       k = KIND_FIQ;
            2:       k = KIND_SERR;
            default: k = KIND_IRQ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/vint_kind_eval.sv
module vint_kind_eval
    import vint_pkg::*;
(
    input  logic [EL_W-1:0] cur_el,
    input  logic            redirect,
    input  logic            phys_line,
    input  logic            virt_line,
    input  logic            mask_bit,
    input  logic            virt_allowed,
    output logic            phys_ok,
    output logic [EL_W-1:0] phys_level,
    output logic            virt_ok
);
    logic guest;

    always_comb begin
        guest      = is_guest_level(cur_el);
        phys_ok    = 1'b0;
        phys_level = LVL_KERNEL;
        if (phys_line) begin
            if (redirect) begin
                phys_level = LVL_HYP;
                if (guest) begin
                    phys_ok = 1'b1;
                end else if (cur_el == LVL_HYP) begin
                    phys_ok = !mask_bit;
                end
            end else if (guest) begin
                phys_ok = !mask_bit;
            end
        end
        virt_ok = virt_line && redirect && guest && virt_allowed && !mask_bit;
    end

endmodule

// File: rtl/vint_prio_pick.sv
module vint_prio_pick
    import vint_pkg::*;
(
    input  logic [NUM_KINDS-1:0]            phys_ok,
    input  logic [NUM_KINDS-1:0][EL_W-1:0]  phys_level,
    input  logic [NUM_KINDS-1:0]            virt_ok,
    output take_info_t                      winner
);
    always_comb begin
        winner = TAKE_NONE;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (virt_ok[k]) begin
                winner = '{valid: 1'b1, kind: kind_of(k), virt: 1'b1, level: LVL_KERNEL};
            end
            if (phys_ok[k]) begin
                winner = '{valid: 1'b1, kind: kind_of(k), virt: 1'b0, level: phys_level[k]};
            end
        end
    end

endmodule

// File: rtl/vint_take_reg.sv
module vint_take_reg
    import vint_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  take_info_t  winner,
    input  logic        ack,
    output logic        pulse,
    output take_info_t  held
);
    logic busy_q;
    logic fire;

    always_comb begin
        fire = winner.valid && !busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pulse  <= 1'b0;
            held   <= TAKE_NONE;
        end else begin
            pulse <= fire;
            if (fire) begin
                busy_q <= 1'b1;
                held   <= winner;
            end else if (ack) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/virq_take_unit.sv
module virq_take_unit
    import vint_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EL_W-1:0]       cur_el,
    input  logic                  secure,
    input  logic                  sec_hyp_en,
    input  logic [NUM_KINDS-1:0]  route_to_hyp,
    input  logic [NUM_KINDS-1:0]  soft_vpend,
    input  logic [NUM_CTL-1:0]    ctl_vreq,
    input  logic [NUM_KINDS-1:0]  phys_req,
    input  logic [NUM_KINDS-1:0]  pstate_mask,
    input  logic                  take_ack,
    output logic                  take_pulse,
    output logic [KIND_W-1:0]     take_kind,
    output logic                  take_virtual,
    output logic [EL_W-1:0]       take_level
);
    logic                           virt_allowed;
    logic [NUM_KINDS-1:0]           vreq;
    logic [NUM_KINDS-1:0]           phys_ok;
    logic [NUM_KINDS-1:0][EL_W-1:0] phys_level;
    logic [NUM_KINDS-1:0]           virt_ok;
    take_info_t                     winner;
    take_info_t                     held;

    assign virt_allowed = !secure || sec_hyp_en;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        if (k < NUM_CTL) begin : g_with_ctl
            assign vreq[k] = soft_vpend[k] | ctl_vreq[k];
        end else begin : g_soft_only
            assign vreq[k] = soft_vpend[k];
        end

        vint_kind_eval u_eval (
            .cur_el       (cur_el),
            .redirect     (route_to_hyp[k]),
            .phys_line    (phys_req[k]),
            .virt_line    (vreq[k]),
            .mask_bit     (pstate_mask[k]),
            .virt_allowed (virt_allowed),
            .phys_ok      (phys_ok[k]),
            .phys_level   (phys_level[k]),
            .virt_ok      (virt_ok[k])
        );
    end

    vint_prio_pick u_pick (
        .phys_ok    (phys_ok),
        .phys_level (phys_level),
        .virt_ok    (virt_ok),
        .winner     (winner)
    );

    vint_take_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .winner (winner),
        .ack    (take_ack),
        .pulse  (take_pulse),
        .held   (held)
    );

    assign take_kind    = held.kind;
    assign take_virtual = held.virt;
    assign take_level   = held.level;

endmodule

// File: rtl/vint_take_chk.sv
module vint_take_chk
    import vint_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [EL_W-1:0]       cur_el,
    input logic                  secure,
    input logic                  sec_hyp_en,
    input logic [NUM_KINDS-1:0]  route_to_hyp,
    input logic [NUM_KINDS-1:0]  pstate_mask,
    input logic                  take_ack,
    input logic                  take_pulse,
    input logic [KIND_W-1:0]     take_kind,
    input logic                  take_virtual,
    input logic [EL_W-1:0]       take_level
);
    logic              awaiting_q;
    logic [EL_W-1:0]   el_q;
    logic              sec_q;
    logic              shen_q;
    logic [3:0]        route_q;
    logic [3:0]        mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            awaiting_q <= 1'b0;
            el_q       <= '0;
            sec_q      <= 1'b0;
            shen_q     <= 1'b0;
            route_q    <= '0;
            mask_q     <= '0;
        end else begin
            if (take_ack) begin
                awaiting_q <= 1'b0;
            end else if (take_pulse) begin
                awaiting_q <= 1'b1;
            end
            el_q    <= cur_el;
            sec_q   <= secure;
            shen_q  <= sec_hyp_en;
            route_q <= {1'b0, route_to_hyp};
            mask_q  <= {1'b0, pstate_mask};
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        take_pulse |=> !take_pulse);                                            // R10
    AST_NO_TAKE_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> !awaiting_q);                                            // R10
    AST_VIRT_GUEST_ONLY: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_virtual) |-> is_guest_level(el_q));                 // R1
    AST_VIRT_TO_KERNEL: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_virtual) |-> (take_level == LVL_KERNEL));           // R5
    AST_VIRT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_virtual) |-> !mask_q[take_kind]);                   // R5
    AST_VIRT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_virtual) |-> route_q[take_kind]);                   // R3
    AST_SECURE_GATE: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_virtual) |-> (!sec_q || shen_q));                   // R7
    AST_ROUTED_PHYS_HYP: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && !take_virtual && route_q[take_kind]) |-> (take_level == LVL_HYP)); // R2
    AST_NO_TAKE_AT_MON: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> (el_q != LVL_MON));                                      // R2
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> (take_kind != 2'b11));                                   // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !take_pulse);                                            // R11

endmodule

bind virq_take_unit vint_take_chk u_chk (.*);

// File: tb/virq_take_unit_tb.sv
module virq_take_unit_tb;
    import vint_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cur_el;
    logic       secure, sec_hyp_en;
    logic [2:0] route_to_hyp, soft_vpend, phys_req, pstate_mask;
    logic [1:0] ctl_vreq;
    logic       take_ack;
    logic       take_pulse, take_virtual;
    logic [1:0] take_kind, take_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    virq_take_unit u_dut (.*);

    // {el, sec, sec_hyp, route, soft, ctl, phys, mask, exp_take, exp_kind, exp_virt, exp_lvl}
    localparam int NV = 20;
    localparam logic [23:0] VECS [NV] = '{
        {2'd1,1'b0,1'b0,3'b000,3'b000,2'b00,3'b001,3'b000, 1'b1,2'b00,1'b0,2'd1}, // R3 plain IRQ to level 1
        {2'd1,1'b0,1'b0,3'b000,3'b000,2'b00,3'b001,3'b001, 1'b0,2'b00,1'b0,2'd0}, // R3 masked physical
        {2'd1,1'b0,1'b0,3'b001,3'b000,2'b00,3'b001,3'b001, 1'b1,2'b00,1'b0,2'd2}, // R2 mask ignored
        {2'd1,1'b0,1'b0,3'b001,3'b001,2'b00,3'b000,3'b000, 1'b1,2'b00,1'b1,2'd1}, // R4 soft vIRQ
        {2'd1,1'b0,1'b0,3'b001,3'b001,2'b00,3'b000,3'b001, 1'b0,2'b00,1'b0,2'd0}, // R5 I masks virtual
        {2'd1,1'b0,1'b0,3'b001,3'b000,2'b01,3'b000,3'b000, 1'b1,2'b00,1'b1,2'd1}, // R4 ctl vIRQ
        {2'd2,1'b0,1'b0,3'b001,3'b000,2'b01,3'b000,3'b000, 1'b0,2'b00,1'b0,2'd0}, // R1 virtual at level 2
        {2'd0,1'b0,1'b0,3'b000,3'b001,2'b00,3'b000,3'b000, 1'b0,2'b00,1'b0,2'd0}, // R3 no redirect no virtual
        {2'd1,1'b0,1'b0,3'b010,3'b000,2'b10,3'b001,3'b000, 1'b1,2'b01,1'b1,2'd1}, // R6 vFIQ with phys IRQ
        {2'd1,1'b1,1'b0,3'b111,3'b100,2'b00,3'b000,3'b000, 1'b0,2'b00,1'b0,2'd0}, // R7 secure blocked
        {2'd1,1'b1,1'b1,3'b100,3'b100,2'b00,3'b000,3'b000, 1'b1,2'b10,1'b1,2'd1}, // R7 secure allowed
        {2'd0,1'b0,1'b0,3'b111,3'b100,2'b10,3'b001,3'b000, 1'b1,2'b10,1'b1,2'd1}, // R8 vSError first
        {2'd1,1'b0,1'b0,3'b100,3'b100,2'b00,3'b100,3'b000, 1'b1,2'b10,1'b0,2'd2}, // R8 phys over virt
        {2'd1,1'b0,1'b0,3'b111,3'b000,2'b10,3'b010,3'b000, 1'b1,2'b01,1'b0,2'd2}, // R8 phys FIQ
        {2'd2,1'b0,1'b0,3'b001,3'b000,2'b00,3'b001,3'b000, 1'b1,2'b00,1'b0,2'd2}, // R2 at level 2
        {2'd2,1'b0,1'b0,3'b001,3'b000,2'b00,3'b001,3'b001, 1'b0,2'b00,1'b0,2'd0}, // R2 masked at level 2
        {2'd3,1'b0,1'b0,3'b111,3'b000,2'b00,3'b111,3'b000, 1'b0,2'b00,1'b0,2'd0}, // R2 level 3
        {2'd2,1'b0,1'b0,3'b000,3'b000,2'b00,3'b001,3'b000, 1'b0,2'b00,1'b0,2'd0}, // R3 unrouted at level 2
        {2'd1,1'b0,1'b0,3'b001,3'b000,2'b00,3'b010,3'b001, 1'b1,2'b01,1'b0,2'd1}, // R6 FIQ independent
        {2'd1,1'b0,1'b0,3'b001,3'b001,2'b00,3'b001,3'b001, 1'b1,2'b00,1'b0,2'd2}  // R5 virt masked phys goes
    };

    task automatic idle_inputs();
        cur_el = 2'd1; secure = 0; sec_hyp_en = 0;
        route_to_hyp = 0; soft_vpend = 0; ctl_vreq = 0; phys_req = 0; pstate_mask = 0;
        take_ack = 0;
    endtask

    task automatic check(input string req, input logic ep, input logic [1:0] ek,
                         input logic ev, input logic [1:0] el);
        logic ok;
        n_checks++;
        ok = (take_pulse === ep);
        if (ep) ok = ok && (take_kind === ek) && (take_virtual === ev) && (take_level === el);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got pulse=%b kind=%b virt=%b lvl=%0d, expected pulse=%b kind=%b virt=%b lvl=%0d",
                     req, take_pulse, take_kind, take_virtual, take_level, ep, ek, ev, el);
        end
    endtask

    task automatic clear_and_ack();
        @(negedge clk);
        idle_inputs();
        take_ack = 1;
        @(negedge clk);
        take_ack = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1;
        phys_req = 3'b001;
        repeat (2) @(posedge clk);
        #1 check("R11 reset state", 1'b0, 2'b00, 1'b0, 2'd0);
        n_checks++;
        if (take_kind !== 0 || take_virtual !== 0 || take_level !== 0) begin
            n_fail++;
            $display("FAIL R11 fields: got %b/%b/%0d, expected 0/0/0", take_kind, take_virtual, take_level);
        end
        @(negedge clk);
        idle_inputs();
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VECS[i];
            @(negedge clk);
            cur_el = v[23:22]; secure = v[21]; sec_hyp_en = v[20];
            route_to_hyp = v[19:17]; soft_vpend = v[16:14]; ctl_vreq = v[13:12];
            phys_req = v[11:9]; pstate_mask = v[8:6];
            @(posedge clk);
            #1 check($sformatf("vector %0d R9", i), v[5], v[4:3], v[2], v[1:0]);
            clear_and_ack();
        end

        // R10: single pulse, hold until acknowledge, re-take after it
        @(negedge clk);
        route_to_hyp = 3'b001; phys_req = 3'b001;
        @(posedge clk);
        #1 check("R10 first pulse", 1'b1, 2'b00, 1'b0, 2'd2);
        @(posedge clk);
        #1 check("R10 pulse one cycle", 1'b0, 2'b00, 1'b0, 2'd0);
        @(posedge clk);
        #1 check("R10 no take before ack", 1'b0, 2'b00, 1'b0, 2'd0);
        @(negedge clk);
        take_ack = 1;
        @(posedge clk);
        #1 check("R10 ack edge no pulse", 1'b0, 2'b00, 1'b0, 2'd0);
        @(negedge clk);
        take_ack = 0;
        @(posedge clk);
        #1 check("R10 retake after ack", 1'b1, 2'b00, 1'b0, 2'd2);

        // R11: reset clears the wait for acknowledge
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1 check("R11 reset while busy", 1'b0, 2'b00, 1'b0, 2'd0);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #1 check("R11 take after reset", 1'b1, 2'b00, 1'b0, 2'd2);
        clear_and_ack();

        // R1: virtual request held at level 2, taken after return to level 1
        @(negedge clk);
        cur_el = 2'd2; route_to_hyp = 3'b001; ctl_vreq = 2'b01;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1 check("R1 pending at level 2", 1'b0, 2'b00, 1'b0, 2'd0);
        end
        @(negedge clk);
        cur_el = 2'd1;
        @(posedge clk);
        #1 check("R1 taken after return", 1'b1, 2'b00, 1'b1, 2'd1);
        clear_and_ack();

        finish_run();
    end

endmodule